// File: doc/BRIEF.md
# Wishbone Gateway with Access Timeout

This block turns a simple single-transfer CPU request/response port into a Wishbone master. A one-cycle request pulse, taken only while the gateway is idle, starts one bus cycle. All outgoing bus signals come from registers. The cycle ends when the device acknowledges it, when the device signals an error, or when a countdown runs out. In each case the CPU sees exactly one response pulse that carries read data and an error flag.

Three parameters fix the behaviour of each instance. `PIPE_STB` chooses between classic strobing (strobe held for the whole cycle) and pipelined strobing (strobe only in the first bus cycle). `TIMEOUT` sets how many bus cycles the gateway waits before it aborts; a value of zero means it waits indefinitely. `ASYNC_RX` removes the register stage on the incoming acknowledge, error and data signals. With that stage in place, the round trip has one outgoing register and one incoming register. A 3-bit tag goes with every access and marks its privilege level and whether it is an instruction fetch.

Top module: `wb_gateway`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o`, `wb_we_o` and `rsp_valid_o` are 0 and `idle_o` is 1.
- R2: A request is accepted only while `idle_o` is 1. On the clock edge that accepts it, `wb_cyc_o` and `wb_stb_o` go to 1 and `wb_adr_o` takes the request address. A request raised while a cycle is in progress is ignored. `wb_stb_o` is never 1 without `wb_cyc_o`.
- R3: With `PIPE_STB=0`, `wb_stb_o` stays 1 in every bus cycle until the cycle ends.
- R4: With `PIPE_STB=1`, `wb_stb_o` is 1 only in the first bus cycle. `wb_cyc_o`, `wb_adr_o` and `wb_we_o` hold until the end.
- R5: For stores, `wb_dat_o` and `wb_sel_o` carry the write data and byte enables. For loads, both are 0. `wb_we_o`, `wb_adr_o` and `wb_sel_o` stay stable for the whole cycle.
- R6: `wb_tag_o` = {fetch, 0, privileged}: bit 0 is 1 for a privileged access, bit 1 is always 0, and bit 2 is 1 for an instruction fetch.
- R7: With `ASYNC_RX=0`, an acknowledge in bus cycle d gives `rsp_valid_o` in bus cycle d+1, with `rsp_rdata_o` equal to the data sampled with the acknowledge. With `ASYNC_RX=1`, the response appears in bus cycle d.
- R8: A device error ends the cycle with `rsp_valid_o`=1, `rsp_err_o`=1 and `rsp_rdata_o`=0.
- R9: With `TIMEOUT`=T>0, if no response has become visible by bus cycle T, then `rsp_valid_o` and `rsp_err_o` are 1 in bus cycle T and `wb_cyc_o` drops after it. If a response becomes visible in bus cycle T itself, that response wins.
- R10: With `TIMEOUT=0`, a cycle waits for the device however long it takes.
- R11: An acknowledge or error that arrives after a timeout abort produces no response.
- R12: `rsp_valid_o` is a single-cycle pulse. `wb_cyc_o` is 0 in the cycle after it, and `idle_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pulse |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Store data |
| req_be_i | input | DW/8 | Store byte enables |
| req_priv_i | input | 1 | Privileged access |
| req_fetch_i | input | 1 | Instruction fetch |
| idle_o | output | 1 | No cycle in progress; a request would be accepted |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Bus fault (device error or timeout) |
| rsp_rdata_o | output | DW | Read data |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | AW | Address |
| wb_dat_o | output | DW | Write data |
| wb_sel_o | output | DW/8 | Byte selects |
| wb_tag_o | output | 3 | Access tag |
| wb_dat_i | input | DW | Read data |
| wb_ack_i | input | 1 | Acknowledge |
| wb_err_i | input | 1 | Error |

## Verification
The bench drives two instances side by side with the same stimulus. One is classic with registered receive and a timeout of 6; the other is pipelined with asynchronous receive and no timeout. It places an acknowledge exactly on the timeout boundary, where an off-by-one countdown would turn a good response into a fault. It also places one just past the boundary, where an abort that came a cycle late would let the data through. An acknowledge arriving after an abort must not produce a second response, and a stale receive register would show up as one. A request held high during a cycle must not change the address or start a back-to-back cycle. The bench also checks that the pipelined strobe drops after one cycle while the classic strobe stays up.

// File: rtl/wbg_pkg.sv
`timescale 1ns/1ps
package wbg_pkg;
  typedef enum logic {GW_IDLE = 1'b0, GW_BUSY = 1'b1} gw_state_e;

  localparam int unsigned TAG_W = 3;

  function automatic logic [TAG_W-1:0] make_tag(input logic priv, input logic fetch);
    return {fetch, 1'b0, priv};
  endfunction
endpackage

// File: rtl/wbg_rx_reg.sv
`timescale 1ns/1ps
module wbg_rx_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_i,
  input  logic          ack_i,
  input  logic          err_i,
  input  logic [DW-1:0] dat_i,
  output logic          ack_o,
  output logic          err_o,
  output logic [DW-1:0] dat_o
);
  logic hit;
  assign hit = ack_o | err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o <= 1'b0;
      err_o <= 1'b0;
      dat_o <= '0;
    end else begin
      // capture only inside a live cycle, and never twice in a row
      ack_o <= cyc_i & ~hit & ack_i;
      err_o <= cyc_i & ~hit & err_i;
      dat_o <= dat_i;
    end
  end

  assert_single_capture_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o | err_o) |=> !(ack_o | err_o));
endmodule

// File: rtl/wbg_timer.sv
`timescale 1ns/1ps
module wbg_timer #(
  parameter int unsigned TIMEOUT = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int unsigned LOAD = (TIMEOUT > 0) ? TIMEOUT - 1 : 0;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= CW'(LOAD);
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i & (cnt_q == '0);

  assert_start_not_running_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_i);
endmodule

// File: rtl/wb_gateway.sv
`timescale 1ns/1ps
module wb_gateway
  import wbg_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter bit          PIPE_STB = 1'b0,
  parameter int unsigned TIMEOUT  = 255,
  parameter bit          ASYNC_RX = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_we_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [DW/8-1:0]  req_be_i,
  input  logic             req_priv_i,
  input  logic             req_fetch_i,
  output logic             idle_o,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [DW-1:0]    rsp_rdata_o,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic             wb_we_o,
  output logic [AW-1:0]    wb_adr_o,
  output logic [DW-1:0]    wb_dat_o,
  output logic [DW/8-1:0]  wb_sel_o,
  output logic [TAG_W-1:0] wb_tag_o,
  input  logic [DW-1:0]    wb_dat_i,
  input  logic             wb_ack_i,
  input  logic             wb_err_i
);
  localparam int unsigned SW = DW / 8;

  gw_state_e      state_q;
  logic           busy, accept, term;
  logic           rx_ack, rx_err, expire;
  logic [DW-1:0]  rx_dat;

  assign busy   = (state_q == GW_BUSY);
  assign accept = req_i & ~busy;

  // incoming path: registered or straight through
  generate
    if (ASYNC_RX) begin : g_rx_async
      assign rx_ack = wb_ack_i & wb_cyc_o;
      assign rx_err = wb_err_i & wb_cyc_o;
      assign rx_dat = wb_dat_i;
    end else begin : g_rx_reg
      wbg_rx_reg #(.DW(DW)) rx_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .cyc_i (wb_cyc_o),
        .ack_i (wb_ack_i),
        .err_i (wb_err_i),
        .dat_i (wb_dat_i),
        .ack_o (rx_ack),
        .err_o (rx_err),
        .dat_o (rx_dat)
      );
    end

    if (TIMEOUT > 0) begin : g_timer
      wbg_timer #(.TIMEOUT(TIMEOUT)) timer_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (accept),
        .run_i   (busy),
        .expire_o(expire)
      );
    end else begin : g_no_timer
      assign expire = 1'b0;
    end
  endgenerate

  assign term = busy & (rx_ack | rx_err | expire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= GW_IDLE;
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      wb_we_o  <= 1'b0;
      wb_adr_o <= '0;
      wb_dat_o <= '0;
      wb_sel_o <= '0;
      wb_tag_o <= '0;
    end else if (accept) begin
      state_q  <= GW_BUSY;
      wb_cyc_o <= 1'b1;
      wb_stb_o <= 1'b1;
      wb_we_o  <= req_we_i;
      wb_adr_o <= req_addr_i;
      wb_dat_o <= req_we_i ? req_wdata_i : '0;
      wb_sel_o <= req_we_i ? req_be_i : SW'(0);
      wb_tag_o <= make_tag(req_priv_i, req_fetch_i);
    end else if (term) begin
      state_q  <= GW_IDLE;
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      wb_we_o  <= 1'b0;
      wb_dat_o <= '0;
      wb_sel_o <= '0;
      wb_tag_o <= '0;
    end else if (busy && PIPE_STB) begin
      wb_stb_o <= 1'b0;
    end
  end

  assign idle_o      = ~busy;
  assign rsp_valid_o = term;
  assign rsp_err_o   = term & ~rx_ack;
  assign rsp_rdata_o = (busy & rx_ack) ? rx_dat : '0;

  // ---------------- assertions ----------------
  assert_stb_in_cyc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o);

  assert_rsp_ends_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!wb_cyc_o && !rsp_valid_o));

  assert_ctrl_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && !rsp_valid_o) |=> ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_sel_o)));

  assert_late_rsp_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_cyc_o |-> !rsp_valid_o);

  generate
    if (PIPE_STB) begin : g_chk_pipe
      assert_stb_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_stb_o |=> !wb_stb_o);
    end else begin : g_chk_classic
      assert_stb_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_cyc_o && !rsp_valid_o) |=> wb_stb_o);
    end

    if (TIMEOUT > 0) begin : g_chk_timeout
      logic [31:0] chk_cyc_cnt;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        chk_cyc_cnt <= '0;
        else if (!wb_cyc_o) chk_cyc_cnt <= '0;
        else                chk_cyc_cnt <= chk_cyc_cnt + 1;
      end
      assert_cycle_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_cyc_o |-> (chk_cyc_cnt < TIMEOUT));
    end
  endgenerate
endmodule

// File: tb/wb_gateway_tb_top.sv
`timescale 1ns/1ps
module wb_gateway_tb_top;
  localparam int TO = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        req_i = 0, req_we = 0, req_priv = 0, req_fetch = 0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] dev_dat = '0;
  logic        dev_ack = 0, dev_err = 0;

  logic        idle_c, rv_c, re_c, cyc_c, stb_c, we_c;
  logic [31:0] rd_c, adr_c, dat_c;
  logic [3:0]  sel_c;
  logic [2:0]  tag_c;
  logic        idle_p, rv_p, re_p, cyc_p, stb_p, we_p;
  logic [31:0] rd_p, adr_p, dat_p;
  logic [3:0]  sel_p;
  logic [2:0]  tag_p;

  wb_gateway #(.PIPE_STB(1'b0), .TIMEOUT(TO), .ASYNC_RX(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be), .req_priv_i(req_priv), .req_fetch_i(req_fetch),
    .idle_o(idle_c), .rsp_valid_o(rv_c), .rsp_err_o(re_c), .rsp_rdata_o(rd_c),
    .wb_cyc_o(cyc_c), .wb_stb_o(stb_c), .wb_we_o(we_c), .wb_adr_o(adr_c), .wb_dat_o(dat_c),
    .wb_sel_o(sel_c), .wb_tag_o(tag_c), .wb_dat_i(dev_dat), .wb_ack_i(dev_ack), .wb_err_i(dev_err));

  wb_gateway #(.PIPE_STB(1'b1), .TIMEOUT(0), .ASYNC_RX(1'b1)) dut_p_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be), .req_priv_i(req_priv), .req_fetch_i(req_fetch),
    .idle_o(idle_p), .rsp_valid_o(rv_p), .rsp_err_o(re_p), .rsp_rdata_o(rd_p),
    .wb_cyc_o(cyc_p), .wb_stb_o(stb_p), .wb_we_o(we_p), .wb_adr_o(adr_p), .wb_dat_o(dat_p),
    .wb_sel_o(sel_p), .wb_tag_o(tag_p), .wb_dat_i(dev_dat), .wb_ack_i(dev_ack), .wb_err_i(dev_err));

  typedef struct packed {
    logic        we;
    logic [31:0] adr;
    logic [31:0] wdat;
    logic [3:0]  be;
    logic        priv;
    logic        fetch;
    logic [7:0]  dly;
    logic        err;
    logic [31:0] rdat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1000, 32'h0,         4'hF,    1'b1, 1'b1, 8'd1,  1'b0, 32'hA5A5_0001},
    '{1'b1, 32'h0000_2004, 32'hDEAD_BEEF, 4'hF,    1'b0, 1'b0, 8'd3,  1'b0, 32'h0000_0000},
    '{1'b0, 32'h0000_0030, 32'h0,         4'hF,    1'b1, 1'b0, 8'd4,  1'b1, 32'h0000_0000},
    '{1'b1, 32'h0000_0042, 32'h1234_5678, 4'b0011, 1'b1, 1'b0, 8'd5,  1'b0, 32'h0000_0011},
    '{1'b0, 32'h0000_0050, 32'h0,         4'hF,    1'b0, 1'b1, 8'd6,  1'b0, 32'h0000_0077},
    '{1'b0, 32'h0000_0060, 32'h0,         4'hF,    1'b0, 1'b0, 8'd9,  1'b0, 32'h0000_0099},
    '{1'b0, 32'h0000_0070, 32'h0,         4'hF,    1'b1, 1'b0, 8'd40, 1'b0, 32'hCAFE_0040}
  };

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int          got_c, got_p, cnt_c, cnt_p, exp_c;
    logic        err_c_s, err_p_s, exp_err_c;
    logic [31:0] dat_c_s, dat_p_s, exp_dat_c, exp_dat_p;
    string       rq_c;
    got_c = 0; got_p = 0; cnt_c = 0; cnt_p = 0;
    err_c_s = 0; err_p_s = 0; dat_c_s = '0; dat_p_s = '0;
    req_we = v.we; req_addr = v.adr; req_wdata = v.wdat; req_be = v.be;
    req_priv = v.priv; req_fetch = v.fetch; req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    for (int c = 1; c <= int'(v.dly) + 3; c++) begin
      dev_ack = (c == int'(v.dly)) && !v.err;
      dev_err = (c == int'(v.dly)) && v.err;
      dev_dat = (c == int'(v.dly)) ? v.rdat : 32'h0;
      #1;
      if (c == 1) begin
        chk("R2", "c cyc/stb", {30'b0, cyc_c, stb_c}, 32'd3);
        chk("R2", "p cyc/stb", {30'b0, cyc_p, stb_p}, 32'd3);
        chk("R2", "c idle", 32'(idle_c), 32'd0);
        chk("R2", "c adr", adr_c, v.adr);
        chk("R2", "p adr", adr_p, v.adr);
        chk("R5", "c we", 32'(we_c), 32'(v.we));
        chk("R5", "c dat", dat_c, v.we ? v.wdat : 32'h0);
        chk("R5", "p dat", dat_p, v.we ? v.wdat : 32'h0);
        chk("R5", "c sel", 32'(sel_c), v.we ? 32'(v.be) : 32'h0);
        chk("R5", "p sel", 32'(sel_p), v.we ? 32'(v.be) : 32'h0);
        chk("R6", "c tag", 32'(tag_c), 32'({v.fetch, 1'b0, v.priv}));
        chk("R6", "p tag", 32'(tag_p), 32'({v.fetch, 1'b0, v.priv}));
      end
      if (c == 2 && v.dly >= 2) begin
        chk("R3", "c stb held", 32'(stb_c), 32'd1);
        chk("R4", "p stb dropped", 32'(stb_p), 32'd0);
        chk("R4", "p cyc held", 32'(cyc_p), 32'd1);
      end
      if (c == int'(v.dly)) begin
        chk("R5", "p we held", 32'(we_p), 32'(v.we));
        chk("R4", "p adr held", adr_p, v.adr);
        if (int'(v.dly) <= TO) chk("R3", "c stb at end", 32'(stb_c), 32'd1);
      end
      if (rv_c) begin cnt_c++; if (got_c == 0) begin got_c = c; err_c_s = re_c; dat_c_s = rd_c; end end
      if (rv_p) begin cnt_p++; if (got_p == 0) begin got_p = c; err_p_s = re_p; dat_p_s = rd_p; end end
      @(negedge clk);
    end
    dev_ack = 0; dev_err = 0; dev_dat = '0;
    #1;
    if (int'(v.dly) + 1 <= TO) begin
      exp_c = int'(v.dly) + 1; exp_err_c = v.err; exp_dat_c = v.err ? 32'h0 : v.rdat; rq_c = "R7";
    end else begin
      exp_c = TO; exp_err_c = 1'b1; exp_dat_c = 32'h0; rq_c = "R9";
    end
    exp_dat_p = v.err ? 32'h0 : v.rdat;
    chk(rq_c, "c rsp cycle", 32'(got_c), 32'(exp_c));
    chk(v.err ? "R8" : rq_c, "c rsp err", 32'(err_c_s), 32'(exp_err_c));
    chk(v.err ? "R8" : rq_c, "c rsp data", dat_c_s, exp_dat_c);
    chk(v.dly > TO ? "R10" : "R7", "p rsp cycle", 32'(got_p), 32'(v.dly));
    chk(v.err ? "R8" : "R7", "p rsp err", 32'(err_p_s), 32'(v.err));
    chk(v.err ? "R8" : "R7", "p rsp data", dat_p_s, exp_dat_p);
    chk(exp_c == TO ? "R11" : "R12", "c rsp count", 32'(cnt_c), 32'd1);
    chk("R12", "p rsp count", 32'(cnt_p), 32'd1);
    chk("R12", "c idle/cyc after", {30'b0, idle_c, cyc_c}, 32'd2);
    chk("R12", "p idle/cyc after", {30'b0, idle_p, cyc_p}, 32'd2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1: reset state
    chk("R1", "c cyc/stb/we", {29'b0, cyc_c, stb_c, we_c}, 32'd0);
    chk("R1", "p cyc/stb/we", {29'b0, cyc_p, stb_p, we_p}, 32'd0);
    chk("R1", "c idle/rsp", {30'b0, idle_c, rv_c}, 32'd2);
    chk("R1", "p idle/rsp", {30'b0, idle_p, rv_p}, 32'd2);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2: requests while busy are ignored
    req_we = 0; req_addr = 32'h0000_0100; req_be = 4'hF; req_priv = 0; req_fetch = 0; req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'h0000_0200;
    for (int c = 1; c <= 5; c++) begin
      dev_ack = (c == 3);
      dev_dat = (c == 3) ? 32'h0000_5555 : 32'h0;
      if (c == 2) req_i = 1'b0;
      #1;
      if (c == 3) begin
        chk("R2", "c adr kept while busy", adr_c, 32'h0000_0100);
        chk("R2", "p adr kept while busy", adr_p, 32'h0000_0100);
      end
      if (c == 5) begin
        chk("R2", "c no extra cycle", 32'(cyc_c), 32'd0);
        chk("R2", "p no extra cycle", 32'(cyc_p), 32'd0);
      end
      @(negedge clk);
    end
    dev_ack = 0; dev_dat = '0;

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule